// File: doc/BRIEF.md
# Battery Probe Sequencer

This block runs on the host side of a battery-backed byte memory. When the memory's backup cell is weak, the memory discards the first write it receives after power returns. The sequencer uses that behaviour to detect a weak cell. It reads one byte, writes the inverted byte to the same location, and reads the location again. If the inverted value comes back, the write took effect. The cell is then reported healthy, and the original byte is written back, so the probe leaves the memory unchanged. If any other value comes back, the cell is reported weak. In that case the location's contents cannot be trusted, and the sequencer does not try to repair them.

System firmware or a power-up controller starts the probe with a one-cycle start pulse and supplies the address to use. The block drives a simple synchronous request port. It holds a read or write strobe, together with the address and write data, until the memory answers with ready. When the probe ends, it raises a one-cycle done pulse. At the same moment exactly one of two result flags goes high, and that flag stays high until the next accepted start.

Top module: `batt_probe_seq`

## Requirements
- R1: After reset, with no start pulse, the block issues no memory request, and done, busy, batt_ok and batt_low are all low.
- R2: A start pulse seen while idle captures probe_addr and raises busy in the next cycle. The first transaction of the sequence is a read of the captured address.
- R3: A transaction completes in the cycle where its strobe and mem_ready are both high. Until then, the strobe, mem_addr and (for a write) mem_wdata hold their values. mem_rd and mem_wr are never high together.
- R4: The second transaction writes the bitwise inverse of the byte returned by the first read, to the same address.
- R5: The third transaction reads the same address again.
- R6: If the third read returns the inverse of the first read, the block raises batt_ok. Before it finishes, it performs a fourth transaction that writes the first read's byte back to the address.
- R7: If the third read returns any other value, the block raises batt_low and ends after three transactions, with no restore write.
- R8: done is high for exactly one cycle, the cycle after the last transaction completes. In that cycle exactly one of batt_ok and batt_low is high.
- R9: batt_ok and batt_low keep their values until a start pulse is accepted. In the cycle after that start, both read low.
- R10: While busy (including the done cycle), start pulses and changes on probe_addr have no effect on the transactions issued or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to run a probe |
| probe_addr | input | ADDR_W | Location to probe, captured when start is accepted |
| mem_addr | output | ADDR_W | Memory request address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |
| mem_ready | input | 1 | Memory completes the pending request this cycle |
| mem_rdata | input | DATA_W | Read data, valid while mem_ready is high on a read |
| busy | output | 1 | A probe is in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| batt_ok | output | 1 | Last probe found the write effective |
| batt_low | output | 1 | Last probe found the write lost or altered |

## Verification
The hardest case to reach is the weak-cell path. It needs a memory that accepts the inverting write handshake but then returns something other than what was written. A correct memory never does that. The bench's memory model can therefore be set, for each probe, to discard the first write or to store it with one bit flipped. This exercises both the plain lost-write case and the corrupted-location case. Start pulses and address changes are injected during busy under non-zero ready latency, to show the sequence does not restart.

// File: rtl/batt_probe_pkg.sv
// Shared types for the battery probe sequencer.
// Assumes: states are consumed only inside the sequencer hierarchy.
package batt_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ORIG = 3'd1,
        ST_WR_INV  = 3'd2,
        ST_RD_BACK = 3'd3,
        ST_WR_REST = 3'd4,
        ST_FINISH  = 3'd5
    } bp_state_e;

endpackage

// File: rtl/bp_ctrl.sv
// Sequence controller: steps through read, invert-write, read-back and
// optional restore, one memory transaction per state.
// Assumes: mem_ready is only meaningful while a strobe is high.
module bp_ctrl
    import batt_probe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      mem_ready,
    input  logic      back_match,
    output bp_state_e state,
    output logic      start_acc,
    output logic      xfer_done,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      fin_ok,
    output logic      fin_low,
    output logic      done,
    output logic      busy
);

    bp_state_e nxt;

    // Decode strobes and completion events from the current state.
    always_comb begin
        mem_rd    = (state == ST_RD_ORIG) || (state == ST_RD_BACK);
        mem_wr    = (state == ST_WR_INV)  || (state == ST_WR_REST);
        xfer_done = (mem_rd || mem_wr) && mem_ready;
        start_acc = start && (state == ST_IDLE);
        fin_ok    = (state == ST_WR_REST) && xfer_done;
        fin_low   = (state == ST_RD_BACK) && xfer_done && !back_match;
        done      = (state == ST_FINISH);
        busy      = (state != ST_IDLE);
    end

    // Next-state selection; each transaction state waits for completion.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)     nxt = ST_RD_ORIG;
            ST_RD_ORIG: if (xfer_done) nxt = ST_WR_INV;
            ST_WR_INV:  if (xfer_done) nxt = ST_RD_BACK;
            ST_RD_BACK: if (xfer_done) nxt = back_match ? ST_WR_REST : ST_FINISH;
            ST_WR_REST: if (xfer_done) nxt = ST_FINISH;
            ST_FINISH:                 nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/bp_datapath.sv
// Probe datapath: holds the probe address and the original byte, builds
// the write data and compares the read-back value with the inverse.
// Assumes: captures happen only on the controller's completion events.
module bp_datapath
    import batt_probe_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bp_state_e         state,
    input  logic              start_acc,
    input  logic              xfer_done,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              back_match
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] orig_q;
    logic [DATA_W-1:0] inv_q;

    // Capture the probe address when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (start_acc) addr_q <= probe_addr;
    end

    // Capture the original byte when the first read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   orig_q <= '0;
        else if (xfer_done && state == ST_RD_ORIG)    orig_q <= mem_rdata;
    end

    // Inverse of the held byte, write data mux and read-back comparison.
    always_comb begin
        inv_q      = ~orig_q;
        mem_addr   = addr_q;
        mem_wdata  = (state == ST_WR_INV) ? inv_q : orig_q;
        back_match = (mem_rdata == inv_q);
    end

endmodule

// File: rtl/bp_result.sv
// Result register: one flag per outcome, cleared by an accepted start.
// Assumes: fin_ok and fin_low are never high in the same cycle.
module bp_result (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic fin_ok,
    input  logic fin_low,
    output logic batt_ok,
    output logic batt_low
);

    // Hold the outcome of the last probe until the next one starts.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            batt_ok  <= 1'b0;
            batt_low <= 1'b0;
        end else if (fin_ok) begin
            batt_ok  <= 1'b1;
        end else if (fin_low) begin
            batt_low <= 1'b1;
        end
    end

endmodule

// File: rtl/batt_probe_seq.sv
// Top of the battery probe sequencer: wires controller, datapath and
// result register to the memory request port.
// Assumes: the memory keeps mem_ready low until it can answer.
module batt_probe_seq
    import batt_probe_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              batt_ok,
    output logic              batt_low
);

    bp_state_e state;
    logic      start_acc;
    logic      xfer_done;
    logic      back_match;
    logic      fin_ok;
    logic      fin_low;

    bp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mem_ready  (mem_ready),
        .back_match (back_match),
        .state      (state),
        .start_acc  (start_acc),
        .xfer_done  (xfer_done),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .fin_ok     (fin_ok),
        .fin_low    (fin_low),
        .done       (done),
        .busy       (busy)
    );

    bp_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .start_acc  (start_acc),
        .xfer_done  (xfer_done),
        .probe_addr (probe_addr),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .back_match (back_match)
    );

    bp_result u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .fin_ok    (fin_ok),
        .fin_low   (fin_low),
        .batt_ok   (batt_ok),
        .batt_low  (batt_low)
    );

endmodule

// File: rtl/batt_probe_seq_chk.sv
// Port-level protocol checker for the battery probe sequencer.
// Assumes: bound to every instance of batt_probe_seq.
module batt_probe_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] probe_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic              busy,
    input logic              done,
    input logic              batt_ok,
    input logic              batt_low
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    // R2
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_rd && mem_addr == $past(probe_addr)));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (batt_ok ^ batt_low));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && !busy) |=> (done || ($stable(batt_ok) && $stable(batt_low))));

    // R10
    addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(mem_addr));

endmodule

bind batt_probe_seq batt_probe_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .probe_addr (probe_addr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_ready  (mem_ready),
    .busy       (busy),
    .done       (done),
    .batt_ok    (batt_ok),
    .batt_low   (batt_low)
);

// File: tb/batt_probe_seq_test.sv
// Scoreboard bench: the driver queues the expected transactions and
// results for each probe, and the monitor compares them as they occur.
module batt_probe_seq_test;

    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] probe_addr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr;
    logic          mem_ready;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, batt_ok, batt_low;

    always #10 clk = ~clk;

    batt_probe_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .probe_addr(probe_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .batt_ok(batt_ok), .batt_low(batt_low)
    );

    typedef struct {
        bit            wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } txn_t;

    txn_t          exp_q[$];
    bit            res_q[$];
    int            checks = 0;
    int            fails  = 0;
    logic [DW-1:0] mem [int];
    int            lat  = 0;
    int            mode = 0;   // 0 write lands, 1 write lost, 2 write with bit 0 flipped
    int            cnt;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: answers after lat extra cycles with a registered ready.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            cnt       <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            cnt       <= 0;
            if (mem_wr) begin
                if (mode == 0 || !mem.exists(int'(mem_addr)) || mem[int'(mem_addr)] != ~mem_wdata)
                    mem[int'(mem_addr)] = mem_wdata;
                else if (mode == 2)
                    mem[int'(mem_addr)] = mem_wdata ^ 8'h01;
            end
        end else if (mem_rd || mem_wr) begin
            if (cnt >= lat) begin
                mem_ready <= 1'b1;
                if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // Monitor: compare each completed transaction and each result.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R7", "unexpected transaction", 32'(mem_addr), 0);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    check(e.wr == mem_wr, e.tag, "transaction kind", 32'(mem_wr), 32'(e.wr));
                    check(e.a == mem_addr, e.tag, "address", 32'(mem_addr), 32'(e.a));
                    if (e.wr)
                        check(e.d == mem_wdata, e.tag, "write data", 32'(mem_wdata), 32'(e.d));
                end
            end
            if (done) begin
                bit r;
                r = (res_q.size() != 0) ? res_q.pop_front() : 1'b0;
                check(batt_ok == r && batt_low == !r, "R6/R7/R8", "result {ok,low}",
                      {30'd0, batt_ok, batt_low}, {30'd0, r, !r});
                check(exp_q.size() == 0, "R7", "transactions left at done", exp_q.size(), 0);
            end
        end
    end

    // Driver: run one probe and queue what the requirements predict.
    task automatic run_probe(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int m, input int l, input bit poke);
        bit ok;
        int guard;
        logic [DW-1:0] fin;
        ok  = (m == 0);
        mem[int'(a)] = d;
        mode = m;
        lat  = l;
        exp_q.push_back('{0, a, 'x, "R2"});
        exp_q.push_back('{1, a, ~d, "R4"});
        exp_q.push_back('{0, a, 'x, "R5"});
        if (ok) exp_q.push_back('{1, a, d, "R6"});
        res_q.push_back(ok);
        @(negedge clk);
        start = 1'b1;
        probe_addr = a;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        check(!batt_ok && !batt_low, "R9", "results cleared", {batt_ok, batt_low}, 0);
        if (poke) begin
            probe_addr = a ^ 15'h0155;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            start = 1'b1;
            probe_addr = a ^ 15'h2aaa;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R8", "done reached", 32'(done), 1);
        if (poke) start = 1'b1;   // R10: start during the done cycle
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8", "done width", 32'(done), 0);
        check(busy == 1'b0, "R10", "idle after done-cycle start", 32'(busy), 0);
        repeat (5) @(negedge clk);
        check(batt_ok == ok && batt_low == !ok, "R9", "result held",
              {batt_ok, batt_low}, {ok, !ok});
        fin = (m == 0 || m == 1) ? d : (~d ^ 8'h01);
        check(mem[int'(a)] == fin, ok ? "R6" : "R7", "memory after probe",
              32'(mem[int'(a)]), 32'(fin));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        probe_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state with no start
        check(!mem_rd && !mem_wr && !done && !busy && !batt_ok && !batt_low, "R1",
              "outputs after reset", {26'd0, mem_rd, mem_wr, done, busy, batt_ok, batt_low}, 0);

        run_probe(15'h0123, 8'hA5, 0, 0, 0);
        run_probe(15'h7FFF, 8'h00, 0, 3, 0);
        run_probe(15'h0000, 8'hFF, 1, 1, 0);
        run_probe(15'h4321, 8'h3C, 2, 2, 0);
        run_probe(15'h1000, 8'h5A, 0, 4, 1);
        run_probe(15'h2001, 8'h81, 1, 4, 1);
        run_probe(15'h0042, 8'h7E, 0, 0, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && res_q.size() == 0, "R7", "scoreboard drained",
              exp_q.size() + res_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule